// File: doc/BRIEF.md
# Cascaded Second-Order Delta-Sigma Modulator for a Coarse Tuning DAC

This block extends the resolution of a 4-bit resistor DAC that sets a delay-tuning voltage. A fine loop accumulator supplies a word whose top bits are the integer DAC level. The remaining bits form the high part of a fractional word, and a few externally pinned bits complete it as its low part. Two first-order accumulator stages are cascaded. The first integrates the fractional word, and the second integrates the first stage's residue. Their carry bits are recombined into a small signed correction with second-order noise shaping. The correction is added to the integer level. When the DAC output is averaged by an analog low-pass filter, the fractional part is recovered.

The modulator advances only on a one-cycle strobe, which comes from a divided reference clock. One new DAC code leaves the block per strobe, marked by a one-cycle valid. The DAC latches every code and cannot stall, so the output stream has no ready signal and there is no back-pressure. The consumer must accept the code in the cycle in which valid is high.

Top module: `mash11_dsm`

## Requirements
- R1: A synchronous reset, asserted in any cycle, clears both stage accumulators, the delayed second-stage carry, `code` (to 0) and `code_valid` (to 0). A strobe applied during reset is ignored.
- R2: With `strobe` low, no state advances and `code` holds its value.
- R3: `code_valid` is high for exactly the one cycle after each clock edge at which `strobe` was high outside reset. Back-to-back strobes give back-to-back valids.
- R4: The modulator's fractional word is {`loop_word[MOD_W-EXT_W-1:0]`, `ext_lsb`}, with `ext_lsb` in the least significant bits. The integer DAC level is `loop_word[LOOP_W-1 -: DAC_W]`.
- R5: On each strobe the first stage adds the fractional word to its MOD_W-bit sum, and the carry out of that addition is c1. The second stage adds the first stage's new MOD_W-bit sum to its own sum, with carry c2. The correction is c1 + c2 − c2', where c2' is c2 from the previous strobe (0 after reset). Its range is −1 to +2.
- R6: The output code is the integer level plus the correction, saturated to 0 at the bottom and to 2^DAC_W − 1 at the top.
- R7: Starting from reset with a constant input, the corrections over 2^MOD_W strobes add up to the fractional word or to the fractional word plus one.
- R8: With a fractional word of zero after reset, every correction is zero and the code equals the integer level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | One-cycle modulator update enable |
| loop_word | input | DAC_W+MOD_W-EXT_W | Loop accumulator word: integer level over fractional high bits |
| ext_lsb | input | EXT_W | Externally pinned fractional low bits |
| code | output | DAC_W | Saturated DAC code |
| code_valid | output | 1 | High for one cycle when a new code is presented |

## Verification
The bench builds the block with MOD_W = 6, EXT_W = 2 and DAC_W = 4. With these values each stage wraps after 64 strobes, and the whole fractional space is only 64 words. Every fractional word is therefore run for a full 64-strobe period from reset, at a mid-scale level where no clamp applies, so the long-run sum and the zero-input case can be checked exactly for all inputs. Separate runs at levels 0 and 15 push the correction into both saturation limits.

// File: rtl/mash_pkg.sv
package mash_pkg;
  // signed correction produced by the recombination network: -1 .. +2
  typedef logic signed [2:0] corr_t;
  localparam int CORR_MIN = -1;
  localparam int CORR_MAX = 2;
endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] residue,
  output logic         carry
);
  logic [W-1:0] acc;
  logic [W:0]   sum;

  assign sum     = {1'b0, acc} + {1'b0, din};
  assign residue = sum[W-1:0];
  assign carry   = sum[W];

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= sum[W-1:0];
  end
endmodule

// File: rtl/mash_recombine.sv
module mash_recombine
  import mash_pkg::*;
#(
  parameter int DAC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             c1,
  input  logic             c2,
  input  logic [DAC_W-1:0] level,
  output logic [DAC_W-1:0] code,
  output logic             code_valid
);
  localparam int SW = DAC_W + 3;
  localparam logic signed [SW-1:0] TOP = SW'((1 << DAC_W) - 1);

  logic                 c2_d;
  corr_t                corr;
  logic signed [SW-1:0] total;
  logic [DAC_W-1:0]     clamped;

  // differentiate the second stage carry and add the first stage carry
  assign corr  = corr_t'({2'b00, c1}) + corr_t'({2'b00, c2}) - corr_t'({2'b00, c2_d});
  assign total = $signed({3'b000, level}) + SW'(corr);

  always_comb begin
    if (total < 0)        clamped = '0;
    else if (total > TOP) clamped = TOP[DAC_W-1:0];
    else                  clamped = total[DAC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c2_d       <= 1'b0;
      code       <= '0;
      code_valid <= 1'b0;
    end else begin
      code_valid <= en;
      if (en) begin
        c2_d <= c2;
        code <= clamped;
      end
    end
  end
endmodule

// File: rtl/mash11_dsm.sv
module mash11_dsm #(
  parameter int DAC_W = 4,
  parameter int MOD_W = 12,
  parameter int EXT_W = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         strobe,
  input  logic [DAC_W+MOD_W-EXT_W-1:0] loop_word,
  input  logic [EXT_W-1:0]             ext_lsb,
  output logic [DAC_W-1:0]             code,
  output logic                         code_valid
);
  localparam int LOOP_W = DAC_W + MOD_W - EXT_W;
  localparam int HI_W   = MOD_W - EXT_W;

  logic [MOD_W-1:0] frac;
  logic [DAC_W-1:0] level;
  logic [MOD_W-1:0] res1, res2;
  logic             c1, c2;

  assign frac  = {loop_word[HI_W-1:0], ext_lsb};
  assign level = loop_word[LOOP_W-1 -: DAC_W];

  mash_acc_stage #(.W(MOD_W)) u_st1 (
    .clk(clk), .rst(rst), .en(strobe), .din(frac),
    .residue(res1), .carry(c1)
  );

  mash_acc_stage #(.W(MOD_W)) u_st2 (
    .clk(clk), .rst(rst), .en(strobe), .din(res1),
    .residue(res2), .carry(c2)
  );

  mash_recombine #(.DAC_W(DAC_W)) u_comb (
    .clk(clk), .rst(rst), .en(strobe), .c1(c1), .c2(c2),
    .level(level), .code(code), .code_valid(code_valid)
  );
endmodule

// File: rtl/mash11_dsm_chk.sv
module mash11_dsm_chk #(
  parameter int DAC_W = 4,
  parameter int MOD_W = 12,
  parameter int EXT_W = 5
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         strobe,
  input logic [DAC_W+MOD_W-EXT_W-1:0] loop_word,
  input logic [DAC_W-1:0]             code,
  input logic                         code_valid
);
  localparam int LOOP_W = DAC_W + MOD_W - EXT_W;
  localparam int TOPV   = (1 << DAC_W) - 1;

  logic [DAC_W-1:0] lvl;
  logic             armed = 1'b0;
  logic             rst_q = 1'b0;

  assign lvl = loop_word[LOOP_W-1 -: DAC_W];

  always_ff @(posedge clk) begin
    armed <= !rst;
    rst_q <= rst;
  end

  always @(posedge clk) begin
    if (rst_q) begin
      AST_RST_CLEAR: assert (code == '0 && !code_valid); // R1
    end
  end

  AST_VALID_TRACK: assert property (@(posedge clk) disable iff (rst)
    armed |-> (code_valid == $past(strobe))); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(strobe)) |-> $stable(code)); // R2

  AST_CORR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (armed && code_valid) |->
      ((int'(code) >= int'($past(lvl)) - 1) && (int'(code) <= int'($past(lvl)) + 2))); // R5

  AST_CLAMP_TOP: assert property (@(posedge clk) disable iff (rst)
    (armed && code_valid && int'($past(lvl)) == TOPV) |-> (int'(code) >= TOPV - 1)); // R6
endmodule

bind mash11_dsm mash11_dsm_chk #(.DAC_W(DAC_W), .MOD_W(MOD_W), .EXT_W(EXT_W)) u_chk (
  .clk(clk), .rst(rst), .strobe(strobe), .loop_word(loop_word),
  .code(code), .code_valid(code_valid)
);

// File: tb/sim_mash11_dsm.sv
module sim_mash11_dsm;
  localparam int DW = 4;
  localparam int MW = 6;
  localparam int EW = 2;
  localparam int LW = DW + MW - EW;
  localparam int M  = 1 << MW;

  logic          clk = 1'b0;
  logic          rst = 1'b0;
  logic          strobe = 1'b0;
  logic [LW-1:0] loop_word = '0;
  logic [EW-1:0] ext_lsb = '0;
  logic [DW-1:0] code;
  logic          code_valid;

  int n_vec = 0;
  int n_bad = 0;
  int ms1, ms2, mc2d;

  always #2.5 clk = ~clk;

  mash11_dsm #(.DAC_W(DW), .MOD_W(MW), .EXT_W(EW)) u0 (
    .clk(clk), .rst(rst), .strobe(strobe), .loop_word(loop_word),
    .ext_lsb(ext_lsb), .code(code), .code_valid(code_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; strobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0; strobe = 1'b0;
    check(code == '0, "R1 code", int'(code), 0);
    check(!code_valid, "R1 valid", int'(code_valid), 0);
    ms1 = 0; ms2 = 0; mc2d = 0;
  endtask

  // one strobe with level lv and fractional word x; returns the correction seen
  task automatic step(input int lv, input int x, output int corr);
    int s1, c1, r1, s2, c2, y, e;
    loop_word = LW'((lv << (MW - EW)) | (x >> EW));
    ext_lsb   = EW'(x & ((1 << EW) - 1));
    s1 = ms1 + x;  c1 = s1 / M; r1 = s1 % M;
    s2 = ms2 + r1; c2 = s2 / M;
    y  = c1 + c2 - mc2d;
    ms1 = r1; ms2 = s2 % M; mc2d = c2;
    e = lv + y;
    if (e < 0) e = 0;
    if (e > (1 << DW) - 1) e = (1 << DW) - 1;
    @(negedge clk);
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    check(code_valid, "R3 valid after strobe", int'(code_valid), 1);
    check(int'(code) == e, "R4/R5/R6 code", int'(code), e);
    @(negedge clk);
    check(!code_valid, "R3 single pulse", int'(code_valid), 0);
    check(int'(code) == e, "R2 hold", int'(code), e);
    corr = int'(code) - lv;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int c, sum;
    // full sweep of the fractional word at mid-scale level 7
    for (int x = 0; x < M; x++) begin
      do_reset();
      sum = 0;
      for (int k = 0; k < M; k++) begin
        step(7, x, c);
        sum += c;
        if (x == 0) check(c == 0, "R8 zero input", c, 0);
      end
      check(sum == x || sum == x + 1, "R7 long-run sum", sum, x);
    end
    // bottom clamp: level 0, small fraction reaches correction -1
    do_reset();
    for (int k = 0; k < M; k++) step(0, 1, c);
    for (int k = 0; k < M; k++) step(0, 45, c);
    // top clamp: level 15, large fraction reaches correction +2
    do_reset();
    for (int k = 0; k < M; k++) step(15, M - 1, c);
    for (int k = 0; k < M; k++) step(15, 19, c);
    // reset in the middle of activity
    do_reset();
    for (int k = 0; k < 5; k++) step(9, 37, c);
    do_reset();
    step(9, 37, c);
    check(c == 0, "R1 state cleared", c, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule